// File: doc/BRIEF.md
# Host Data-Polling Completion Engine

This block sits on the host side of a parallel flash interface and decides when a program or erase operation already issued to the device has finished. A single start pulse supplies the operation kind, the address to poll and bit 7 of the datum that was written. After a settle delay the engine issues read requests on a valid/ready read channel and examines bit 7 of each returned word. While the device is busy, bit 7 reads as the inverse of its final value. The engine stops when bit 7 reaches its true value. Bit 7 can flip before bits 6 to 0 have settled, so the engine then performs one further read and reports that second word as the valid data.

Completion is reported by a one-cycle done pulse with the result word. If bit 7 never reaches its true value within a programmable number of polls, the engine gives a one-cycle error pulse and returns to idle.

The read channel follows these rules. `rd_valid` rises with `rd_addr`, and both stay unchanged until a clock edge where `rd_ready` is also high. After that handshake exactly one response is outstanding. The device returns the response as a single-cycle `rd_rvalid` with `rd_rdata`. The engine has no back-pressure on responses and does not raise `rd_valid` again until the response has arrived.

Top module: `dpoll_engine`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `rd_valid` are all 0.
- R2: When `start` is sampled high in idle, the first `rd_valid` appears exactly `settle_cycles`+1 clock cycles later.
- R3: Once raised, `rd_valid` stays high with `rd_addr` unchanged until the cycle `rd_ready` is seen. Every read is addressed to the `poll_addr` captured at start.
- R4: For a program (`op_erase`=0), a poll counts as complete when bit 7 of the returned word equals `expect_status_bit`.
- R5: For an erase (`op_erase`=1), a poll counts as complete when bit 7 of the returned word is 1, whatever the value of `expect_status_bit`.
- R6: After the first complete poll, the engine issues exactly one more read. The word from that extra read is the one presented on `result_data`.
- R7: With `word_mode`=1 (captured at start), `result_data` carries all 16 bits of the final word. With `word_mode`=0 it carries bits 7..0, and bits 15..8 are 0.
- R8: If `max_polls` consecutive polls are all incomplete, `error` pulses, no extra read is issued and `done` stays low. A `max_polls` of 0 behaves as 1.
- R9: `done` and `error` are single-cycle pulses and never high together. `busy` is already low in the cycle either of them is high.
- R10: A `start` pulse while `busy` is high is ignored. The running operation keeps its address, limits and outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| op_erase | input | 1 | 1 = erase, 0 = program |
| poll_addr | input | AW | Address to poll |
| expect_status_bit | input | 1 | Bit 7 of the datum programmed |
| word_mode | input | 1 | 1 = 16-bit result, 0 = 8-bit result |
| settle_cycles | input | SW | Delay before the first poll |
| max_polls | input | PW | Incomplete polls allowed before timeout |
| busy | output | 1 | Operation in progress |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read address |
| rd_rvalid | input | 1 | Read response valid, one cycle |
| rd_rdata | input | DW | Read response data |
| done | output | 1 | Completion pulse |
| error | output | 1 | Timeout pulse |
| result_data | output | DW | Final word, valid with `done` |

## Verification
The bench builds the engine with a 12-bit address, 16-bit data, a 4-bit settle counter and a 4-bit poll limit. These sizes put every limit value within a short run.

The bench sweeps the full product of these settings:
- operation kind (program or erase)
- result width (byte or word mode)
- busy length from zero to five polls, against a limit of four
- two settle delays
- varied request-accept delays and response latencies

This reaches both completion and timeout, and also the boundary where the limit is just met. Separate runs cover a limit of 0 and a limit of 1.

The simulated device returns a word whose low bits are still wrong in the read where bit 7 first turns true. Any report of the wrong read therefore shows up as a data mismatch.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  localparam int STATUS_BIT = 7;
  localparam int BYTE_W     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_POLL_REQ,
    ST_POLL_WAIT,
    ST_FIN_REQ,
    ST_FIN_WAIT
  } dp_state_e;
endpackage

// File: rtl/dpoll_settle.sv
module dpoll_settle #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [SW-1:0] limit,
  output logic          expired
);
  logic [SW-1:0] cnt_q;

  assign expired = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear)            cnt_q <= '0;
    else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
  end

  // The count never passes the captured delay (R2)
  assert_settle_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
endmodule

// File: rtl/dpoll_counter.sv
module dpoll_counter #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  input  logic [PW-1:0] limit,
  output logic          last
);
  logic [PW-1:0] cnt_q;

  // the poll under way is the final one permitted; a limit of 0 acts as 1
  assign last = (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt_q < limit));
endmodule

// File: rtl/dpoll_match.sv
module dpoll_match (
  input  logic op_erase,
  input  logic expect_bit,
  input  logic status_bit,
  output logic hit
);
  // an erase drives every bit to 1, so its true status is always 1
  logic true_bit;
  assign true_bit = op_erase ? 1'b1 : expect_bit;
  assign hit      = (status_bit == true_bit);
endmodule

// File: rtl/dpoll_engine.sv
module dpoll_engine #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int SW = 8,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] poll_addr,
  input  logic          expect_status_bit,
  input  logic          word_mode,
  input  logic [SW-1:0] settle_cycles,
  input  logic [PW-1:0] max_polls,
  output logic          busy,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rvalid,
  input  logic [DW-1:0] rd_rdata,
  output logic          done,
  output logic          error,
  output logic [DW-1:0] result_data
);
  import dpoll_pkg::*;

  localparam int HI_W = DW - BYTE_W;

  dp_state_e     state_q, state_d;
  logic          op_q, exp_q, word_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] settle_q;
  logic [PW-1:0] maxp_q;
  logic          done_q, error_q;
  logic [DW-1:0] result_q;

  logic accept, settle_done, hit, last_poll;
  logic poll_resp, poll_miss, fin_resp;

  assign accept    = (state_q == ST_IDLE) && start;
  assign poll_resp = (state_q == ST_POLL_WAIT) && rd_rvalid;
  assign poll_miss = poll_resp && !hit;
  assign fin_resp  = (state_q == ST_FIN_WAIT) && rd_rvalid;

  dpoll_settle #(.SW(SW)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .run     (state_q == ST_SETTLE),
    .limit   (settle_q),
    .expired (settle_done)
  );

  dpoll_counter #(.PW(PW)) u_polls (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .inc   (poll_miss && !last_poll),
    .limit (maxp_q),
    .last  (last_poll)
  );

  dpoll_match u_match (
    .op_erase   (op_q),
    .expect_bit (exp_q),
    .status_bit (rd_rdata[STATUS_BIT]),
    .hit        (hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start) state_d = ST_SETTLE;
      ST_SETTLE:    if (settle_done) state_d = ST_POLL_REQ;
      ST_POLL_REQ:  if (rd_ready) state_d = ST_POLL_WAIT;
      ST_POLL_WAIT: begin
        if (rd_rvalid) begin
          if (hit)            state_d = ST_FIN_REQ;
          else if (last_poll) state_d = ST_IDLE;
          else                state_d = ST_POLL_REQ;
        end
      end
      ST_FIN_REQ:   if (rd_ready) state_d = ST_FIN_WAIT;
      ST_FIN_WAIT:  if (rd_rvalid) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= 1'b0;
      exp_q    <= 1'b0;
      word_q   <= 1'b0;
      addr_q   <= '0;
      settle_q <= '0;
      maxp_q   <= '0;
      done_q   <= 1'b0;
      error_q  <= 1'b0;
      result_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_resp;
      error_q <= poll_miss && last_poll;
      if (accept) begin
        op_q     <= op_erase;
        exp_q    <= expect_status_bit;
        word_q   <= word_mode;
        addr_q   <= poll_addr;
        settle_q <= settle_cycles;
        maxp_q   <= max_polls;
      end
      if (fin_resp)
        result_q <= word_q ? rd_rdata : {{HI_W{1'b0}}, rd_rdata[BYTE_W-1:0]};
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign rd_valid    = (state_q == ST_POLL_REQ) || (state_q == ST_FIN_REQ);
  assign rd_addr     = addr_q;
  assign done        = done_q;
  assign error       = error_q;
  assign result_data = result_q;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_idle_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy);

  assert_byte_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !word_q) |-> (result_data[DW-1:BYTE_W] == '0));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(maxp_q) && $stable(op_q)));
endmodule

// File: tb/dpoll_engine_bench.sv
`timescale 1ns/1ps
module dpoll_engine_bench;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int SW = 4;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_erase = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic          expect_status_bit = 1'b0;
  logic          word_mode = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic [PW-1:0] max_polls = '0;
  logic          busy, rd_valid, done, error;
  logic          rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rd_rvalid = 1'b0;
  logic [DW-1:0] rd_rdata = '0;
  logic [DW-1:0] result_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // per-run scenario
  int            busy_len, rdly, lat;
  logic          cur_erase, cur_b7;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] true_val;

  // device model state
  int   reads, wcnt, done_cnt, err_cnt, first_req_cyc, addr_bad, busy_bad;
  logic pend;
  logic [DW-1:0] last_result;

  dpoll_engine #(.AW(AW), .DW(DW), .SW(SW), .PW(PW)) u_dpoll_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .poll_addr(poll_addr), .expect_status_bit(expect_status_bit),
    .word_mode(word_mode), .settle_cycles(settle_cycles),
    .max_polls(max_polls), .busy(busy), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid),
    .rd_rdata(rd_rdata), .done(done), .error(error),
    .result_data(result_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] dev_word(int i);
    logic [DW-1:0] d;
    if (i <= busy_len)
      d = {8'(8'h3C ^ i), ~true_val[7], 7'(i * 5)};
    else if (i == busy_len + 1)
      d = {8'(8'hEE ^ i), true_val[7], 7'h55};
    else
      d = true_val;
    return d;
  endfunction

  // device model and output monitor, all on the falling edge
  always @(negedge clk) begin
    logic hs;
    hs = rd_ready;
    rd_rvalid = 1'b0;
    if (hs) begin
      rd_ready = 1'b0;
      reads++;
      if (lat == 0) begin
        rd_rvalid = 1'b1;
        rd_rdata  = dev_word(reads);
      end else begin
        pend = 1'b1;
      end
    end else if (pend) begin
      pend      = 1'b0;
      rd_rvalid = 1'b1;
      rd_rdata  = dev_word(reads);
    end
    if (!hs && rd_valid) begin
      if (first_req_cyc < 0) first_req_cyc = cyc;
      if (rd_addr != cur_addr) addr_bad++;
      if (wcnt >= rdly) begin
        rd_ready = 1'b1;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
    if (done) begin
      done_cnt++;
      last_result = result_data;
    end
    if (error) err_cnt++;
    if ((done || error) && busy) busy_bad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input bit er, input bit wm, input int bl, input int st,
                     input int rd, input int lt, input int mp, input bit poke);
    int w;
    int start_cyc;
    int mp_eff;
    bit finish_ok;
    logic [DW-1:0] exp_res;
    busy_len  = bl; rdly = rd; lat = lt;
    cur_erase = er;
    cur_b7    = 1'(wm ^ bl[0]);
    cur_addr  = AW'(12'h100 + bl * 7 + st);
    if (er) true_val = {8'h96, 1'b1, 7'(bl + 16)};
    else    true_val = {8'(8'h5A ^ bl), cur_b7, 7'(bl * 9 + 3)};
    reads = 0; wcnt = 0; done_cnt = 0; err_cnt = 0; first_req_cyc = -1;
    addr_bad = 0; busy_bad = 0; pend = 1'b0; last_result = '0;
    @(negedge clk);
    op_erase = er; word_mode = wm; poll_addr = cur_addr;
    // for an erase the expected bit is set opposite to the true status (R5)
    expect_status_bit = er ? 1'b0 : cur_b7;
    settle_cycles = SW'(st); max_polls = PW'(mp); start = 1'b1;
    @(negedge clk);
    start_cyc = cyc;
    start = 1'b0;
    poll_addr = ~cur_addr; max_polls = '0; op_erase = ~er;
    if (poke) begin
      repeat (2) @(negedge clk);
      if (busy) begin
        start = 1'b1; // R10: must be ignored
        @(negedge clk);
        start = 1'b0;
      end
    end
    w = 0;
    while (done_cnt + err_cnt == 0 && w < 500) begin
      @(negedge clk);
      w++;
    end
    repeat (8) @(negedge clk);
    mp_eff    = (mp == 0) ? 1 : mp;
    finish_ok = (bl < mp_eff);
    exp_res   = wm ? true_val : {8'h00, true_val[7:0]};
    chk(first_req_cyc - start_cyc == st + 1, "R2 settle delay",
        first_req_cyc - start_cyc, st + 1);
    chk(addr_bad == 0, "R3 read address", addr_bad, 0);
    chk(busy_bad == 0, "R9 busy low at finish", busy_bad, 0);
    if (finish_ok) begin
      chk(done_cnt == 1 && err_cnt == 0, er ? "R5 erase completion" : "R4 program completion",
          done_cnt * 16 + err_cnt, 16);
      chk(reads == bl + 2, "R6 one extra read", reads, bl + 2);
      chk(last_result == exp_res, wm ? "R7 word result R6" : "R7 byte result R6",
          int'(last_result), int'(exp_res));
    end else begin
      chk(err_cnt == 1 && done_cnt == 0, "R8 timeout pulse", done_cnt * 16 + err_cnt, 1);
      chk(reads == mp_eff, "R8 no extra read", reads, mp_eff);
    end
    if (poke) chk(!busy, "R10 ignored start left idle", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !rd_valid, "R1 reset state",
        {busy, done, error, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_valid, "R1 idle after reset", {busy, rd_valid}, 0);
    for (int er = 0; er < 2; er++)
      for (int wm = 0; wm < 2; wm++)
        for (int bl = 0; bl < 6; bl++)
          for (int st = 0; st < 4; st += 3)
            run(1'(er), 1'(wm), bl, st, bl % 3, (bl + st) % 2, 4, 1'(bl[0] ^ wm));
    // limit edge cases (R8)
    run(1'b0, 1'b1, 0, 1, 0, 0, 0, 1'b0);
    run(1'b1, 1'b0, 2, 0, 1, 1, 0, 1'b0);
    run(1'b0, 1'b0, 1, 2, 0, 1, 1, 1'b1);
    run(1'b1, 1'b1, 0, 0, 2, 0, 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule